// File: doc/BRIEF.md
# Virtually Tagged Write-Through Snooping Cache

This block is a small direct-mapped first-level data cache. It is indexed and tagged by virtual address. Each line also stores the address-space identifier of the process that filled it, so two processes that use the same virtual address never hit on each other's data. A line is 64 bytes on a 64-byte boundary. Transfers to and from memory always carry a whole line, and a byte mask picks the bytes that a write changes.

Every CPU store is written through to memory at once. When the store hits a resident line, that line's copy is updated as well. A store miss does not allocate a line. The cache also watches a bus that carries writes made by other agents. Any resident line whose memory address is written there is dropped, so the next access to it refills from memory. Memory addresses are taken equal to virtual addresses, because translation is outside this block. A snoop matches a line on address alone, whatever identifier the line holds.

The CPU holds its request until `cpu_ready` is seen high. A read hit completes in the cycle it is presented. A read miss completes in the cycle the memory acknowledges the refill. A write completes in the cycle the memory acknowledges the write.

Top module: `vtag_wt_cache`

## Requirements
- R1: After reset no line is valid, so the first read of any address misses and issues a memory read.
- R2: A read miss raises `mem_req` with `mem_we` low and a line address whose bits [5:0] are zero. It holds that request stable with `cpu_ready` low until `mem_ack`. In the acknowledge cycle it returns the 32-bit word selected by address bits [5:2], where word w sits in bits [32w+31:32w] of the line.
- R3: After a refill, a read of any word of that line with the same ASID hits. `cpu_ready` is high in the first cycle and no memory request is made.
- R4: A hit needs the stored ASID to equal the request ASID. A read of a resident virtual address under another ASID misses and replaces the line.
- R5: Address bits [9:6] select one of 16 sets, and bits [31:10] form the tag. Two addresses with the same set and different tags evict each other.
- R6: Every CPU write issues a memory write: `mem_we` high, the line-aligned address, the data in word position bits [5:2], and exactly the 4 byte-enable bits 4w..4w+3 of `mem_be` set (bit b enables byte b). `cpu_ready` rises only on `mem_ack`.
- R7: A write that hits also updates the cached word, so a following read hits and returns the new data.
- R8: A write miss allocates no line, so a following read of that address misses.
- R9: A snoop whose line address (`snoop_line` = address bits [31:6]) matches a resident line invalidates it, whatever the ASID, and the next read misses and refills.
- R10: A snoop to the requested line in the same cycle as a read that would hit takes priority. The read is treated as a miss.
- R11: A snoop to the line being refilled, seen between the request and the acknowledge, still lets the refilled word go to the CPU, but the line is not left valid.
- R12: A snoop to an address that is not resident leaves other lines valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_vaddr | input | 32 | Virtual byte address |
| cpu_asid | input | 8 | Address-space identifier |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready on a read |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 512 | Line-wide write data |
| mem_be | output | 64 | Byte enables for a write |
| mem_ack | input | 1 | Memory handshake complete |
| mem_rdata | input | 512 | Refill line, valid with mem_ack |
| snoop_valid | input | 1 | A remote write is on the snoop bus |
| snoop_line | input | 26 | Line address of the remote write |

## Verification
The bench targets the ASID check: a design that ignores it would hit on the second process's read and return the first process's data, skipping the refill. It also targets same-set eviction and write-miss non-allocation: a design that got either wrong would produce a hit where the bench expects a memory read. Snoops are aimed at a resident line, an unrelated line, the line being read in the same cycle, and the line in flight during a refill. A design with the wrong snoop priority, or one that validates a line poisoned during its refill, would serve stale data without going to memory. After a write hit the bench reads the line back as a hit, which catches a cache that writes memory but leaves its own copy stale.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WRITE = 2'd2
   } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int SETS   = 16,
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 22,
   parameter int ASID_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   output logic              lk_valid,
   output logic [TAG_W-1:0]  lk_tag,
   output logic [ASID_W-1:0] lk_asid,
   input  logic              sn_valid,
   input  logic [IDX_W-1:0]  sn_idx,
   input  logic [TAG_W-1:0]  sn_tag,
   input  logic              fl_en,
   input  logic [IDX_W-1:0]  fl_idx,
   input  logic [TAG_W-1:0]  fl_tag,
   input  logic [ASID_W-1:0] fl_asid,
   input  logic              fl_keep
);
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [ASID_W-1:0] asid_q [SETS];
   logic [SETS-1:0]   valid_q;

   // one valid bit per set; a refill of the set wins over a snoop to it
   for (genvar s = 0; s < SETS; s++) begin : g_valid
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            valid_q[s] <= 1'b0;
         else if (fl_en && fl_idx == IDX_W'(s))
            valid_q[s] <= fl_keep;
         else if (sn_valid && sn_idx == IDX_W'(s) && tag_q[s] == sn_tag)
            valid_q[s] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (fl_en) begin
         tag_q[fl_idx]  <= fl_tag;
         asid_q[fl_idx] <= fl_asid;
      end
   end

   assign lk_valid = valid_q[lk_idx];
   assign lk_tag   = tag_q[lk_idx];
   assign lk_asid  = asid_q[lk_idx];
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
   parameter int SETS   = 16,
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32,
   parameter int WORDS  = 16,
   parameter int WSEL_W = 4,
   parameter int LINE_W = 512
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_wsel,
   output logic [DATA_W-1:0] rd_word,
   input  logic              fl_en,
   input  logic [IDX_W-1:0]  fl_idx,
   input  logic [LINE_W-1:0] fl_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_wsel,
   input  logic [DATA_W-1:0] wr_data
);
   logic [LINE_W-1:0] line_q [SETS];
   logic [LINE_W-1:0] rd_line;

   always_ff @(posedge clk) begin
      if (fl_en)
         line_q[fl_idx] <= fl_line;
      else if (wr_en)
         line_q[wr_idx][wr_wsel*DATA_W +: DATA_W] <= wr_data;
   end

   assign rd_line = line_q[rd_idx];
   assign rd_word = rd_line[rd_wsel*DATA_W +: DATA_W];

   logic unused_words;
   assign unused_words = (WORDS == 0);
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
   import wtc_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int ASID_W   = 8,
   parameter int DATA_W   = 32,
   parameter int OFF_W    = 6,
   parameter int BYTE_OFF = 2,
   parameter int IDX_W    = 4,
   parameter int TAG_W    = 22,
   parameter int WSEL_W   = 4,
   parameter int WORDS    = 16,
   parameter int LINE_W   = 512,
   parameter int BE_W     = 64,
   parameter int LINE_AW  = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_vaddr,
   input  logic [ASID_W-1:0] cpu_asid,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   output logic [BE_W-1:0]   mem_be,
   input  logic              mem_ack,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              snoop_valid,
   input  logic [LINE_AW-1:0] snoop_line,
   output logic [IDX_W-1:0]  lk_idx,
   input  logic              lk_valid,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [ASID_W-1:0] lk_asid,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [WSEL_W-1:0] rd_wsel,
   input  logic [DATA_W-1:0] rd_word,
   output logic              fl_en,
   output logic              fl_keep,
   output logic [IDX_W-1:0]  r_idx,
   output logic [TAG_W-1:0]  r_tag,
   output logic [ASID_W-1:0] r_asid_o,
   output logic              wr_en,
   output logic [WSEL_W-1:0] r_wsel,
   output logic [DATA_W-1:0] r_wdata_o
);
   localparam int BPW = DATA_W / 8;

   wtc_state_e        state_q, state_d;
   logic [ADDR_W-1:0] r_addr_q;
   logic [ASID_W-1:0] r_asid_q;
   logic [DATA_W-1:0] r_wdata_q;
   logic              poison_q, poison_d;
   logic              take;

   logic [IDX_W-1:0]   c_idx;
   logic [TAG_W-1:0]   c_tag;
   logic [WSEL_W-1:0]  c_wsel;
   logic [LINE_AW-1:0] c_line, r_line;
   logic               conflict_c, conflict_r, lk_hit, idle;

   assign c_wsel = cpu_vaddr[OFF_W-1:BYTE_OFF];
   assign c_idx  = cpu_vaddr[OFF_W+IDX_W-1:OFF_W];
   assign c_tag  = cpu_vaddr[ADDR_W-1:OFF_W+IDX_W];
   assign c_line = cpu_vaddr[ADDR_W-1:OFF_W];
   assign r_wsel = r_addr_q[OFF_W-1:BYTE_OFF];
   assign r_idx  = r_addr_q[OFF_W+IDX_W-1:OFF_W];
   assign r_tag  = r_addr_q[ADDR_W-1:OFF_W+IDX_W];
   assign r_line = r_addr_q[ADDR_W-1:OFF_W];
   assign r_asid_o  = r_asid_q;
   assign r_wdata_o = r_wdata_q;

   assign idle       = (state_q == ST_IDLE);
   assign conflict_c = snoop_valid && snoop_line == c_line;
   assign conflict_r = snoop_valid && snoop_line == r_line;
   assign lk_idx     = idle ? c_idx : r_idx;
   assign lk_hit     = lk_valid && lk_tag == (idle ? c_tag : r_tag)
                       && lk_asid == (idle ? cpu_asid : r_asid_q);
   assign rd_idx     = c_idx;
   assign rd_wsel    = c_wsel;

   assign mem_addr = {r_line, {OFF_W{1'b0}}};
   for (genvar w = 0; w < WORDS; w++) begin : g_wlane
      assign mem_wdata[w*DATA_W +: DATA_W] = (r_wsel == WSEL_W'(w)) ? r_wdata_q : '0;
      assign mem_be[w*BPW +: BPW] = {BPW{state_q == ST_WRITE && r_wsel == WSEL_W'(w)}};
   end

   always_comb begin
      state_d   = state_q;
      poison_d  = poison_q;
      take      = 1'b0;
      cpu_ready = 1'b0;
      cpu_rdata = '0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      fl_en     = 1'b0;
      fl_keep   = 1'b0;
      wr_en     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cpu_req) begin
               if (cpu_we) begin
                  take    = 1'b1;
                  state_d = ST_WRITE;
               end else if (lk_hit && !conflict_c) begin
                  cpu_ready = 1'b1;
                  cpu_rdata = rd_word;
               end else begin
                  take    = 1'b1;
                  state_d = ST_FILL;
               end
            end
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            poison_d = poison_q || conflict_r;
            if (mem_ack) begin
               fl_en     = 1'b1;
               fl_keep   = !(poison_q || conflict_r);
               cpu_ready = 1'b1;
               cpu_rdata = mem_rdata[r_wsel*DATA_W +: DATA_W];
               state_d   = ST_IDLE;
            end
         end
         ST_WRITE: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_ack) begin
               cpu_ready = 1'b1;
               wr_en     = lk_hit && !conflict_r;
               state_d   = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
      if (take) poison_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         r_addr_q  <= '0;
         r_asid_q  <= '0;
         r_wdata_q <= '0;
         poison_q  <= 1'b0;
      end else begin
         state_q  <= state_d;
         poison_q <= poison_d;
         if (take) begin
            r_addr_q  <= cpu_vaddr;
            r_asid_q  <= cpu_asid;
            r_wdata_q <= cpu_wdata;
         end
      end
   end

   logic unused_low;
   assign unused_low = ^{r_addr_q[BYTE_OFF-1:0]};
endmodule

// File: rtl/vtag_wt_cache.sv
module vtag_wt_cache #(
   parameter int ADDR_W     = 32,
   parameter int ASID_W     = 8,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 16,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = 8 * LINE_BYTES,
   localparam int LINE_AW   = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_vaddr,
   input  logic [ASID_W-1:0]  cpu_asid,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic               cpu_ready,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [LINE_W-1:0]  mem_wdata,
   output logic [LINE_BYTES-1:0] mem_be,
   input  logic               mem_ack,
   input  logic [LINE_W-1:0]  mem_rdata,
   input  logic               snoop_valid,
   input  logic [LINE_AW-1:0] snoop_line
);
   localparam int BYTE_OFF = $clog2(DATA_W / 8);
   localparam int WORDS    = LINE_BYTES / (DATA_W / 8);
   localparam int WSEL_W   = $clog2(WORDS);
   localparam int IDX_W    = $clog2(SETS);
   localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;

   if (LINE_BYTES != (1 << OFF_W)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (SETS != (1 << IDX_W)) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (DATA_W % 8 != 0 || WORDS < 2) begin : g_bad_data
      $error("DATA_W must be whole bytes and narrower than a line");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   logic [IDX_W-1:0]  lk_idx, rd_idx, r_idx;
   logic              lk_valid, fl_en, fl_keep, wr_en;
   logic [TAG_W-1:0]  lk_tag, r_tag;
   logic [ASID_W-1:0] lk_asid, r_asid;
   logic [WSEL_W-1:0] rd_wsel, r_wsel;
   logic [DATA_W-1:0] rd_word, r_wdata;

   wtc_ctrl #(
      .ADDR_W(ADDR_W), .ASID_W(ASID_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
      .BYTE_OFF(BYTE_OFF), .IDX_W(IDX_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W),
      .WORDS(WORDS), .LINE_W(LINE_W), .BE_W(LINE_BYTES), .LINE_AW(LINE_AW)
   ) i_ctrl (
      .clk, .rst_n, .cpu_req, .cpu_we, .cpu_vaddr, .cpu_asid, .cpu_wdata,
      .cpu_ready, .cpu_rdata, .mem_req, .mem_we, .mem_addr, .mem_wdata,
      .mem_be, .mem_ack, .mem_rdata, .snoop_valid, .snoop_line,
      .lk_idx, .lk_valid, .lk_tag, .lk_asid, .rd_idx, .rd_wsel, .rd_word,
      .fl_en, .fl_keep, .r_idx, .r_tag, .r_asid_o(r_asid), .wr_en,
      .r_wsel, .r_wdata_o(r_wdata)
   );

   wtc_tag_store #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .ASID_W(ASID_W)
   ) i_tags (
      .clk, .rst_n, .lk_idx, .lk_valid, .lk_tag, .lk_asid,
      .sn_valid(snoop_valid), .sn_idx(snoop_line[IDX_W-1:0]),
      .sn_tag(snoop_line[LINE_AW-1:IDX_W]),
      .fl_en, .fl_idx(r_idx), .fl_tag(r_tag), .fl_asid(r_asid), .fl_keep
   );

   wtc_data_store #(
      .SETS(SETS), .IDX_W(IDX_W), .DATA_W(DATA_W), .WORDS(WORDS),
      .WSEL_W(WSEL_W), .LINE_W(LINE_W)
   ) i_data (
      .clk, .rd_idx, .rd_wsel, .rd_word, .fl_en, .fl_idx(r_idx),
      .fl_line(mem_rdata), .wr_en, .wr_idx(r_idx), .wr_wsel(r_wsel),
      .wr_data(r_wdata)
   );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
   parameter int ADDR_W  = 32,
   parameter int OFF_W   = 6,
   parameter int LINE_AW = 26,
   parameter int BE_W    = 64,
   parameter int BPW     = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_req,
   input logic               cpu_we,
   input logic [ADDR_W-1:0]  cpu_vaddr,
   input logic               cpu_ready,
   input logic               mem_req,
   input logic               mem_we,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic [BE_W-1:0]    mem_be,
   input logic               mem_ack,
   input logic               snoop_valid,
   input logic [LINE_AW-1:0] snoop_line
);
   // R2
   mem_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[OFF_W-1:0] == '0);

   // R2
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R2
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |-> !cpu_ready);

   // R6
   write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> $countones(mem_be) == BPW);

   // R6
   write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_we && cpu_ready |-> mem_req && mem_we && mem_ack);

   // R10
   snoop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_we && !mem_req && snoop_valid
      && snoop_line == cpu_vaddr[ADDR_W-1:OFF_W] |-> !cpu_ready);

   logic unused_low;
   assign unused_low = ^{cpu_vaddr[OFF_W-1:0]};
endmodule

bind vtag_wt_cache wtc_checker #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_AW(LINE_AW),
   .BE_W(LINE_BYTES), .BPW(DATA_W / 8)
) i_wtc_checker (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_vaddr(cpu_vaddr), .cpu_ready(cpu_ready), .mem_req(mem_req),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
   .mem_ack(mem_ack), .snoop_valid(snoop_valid), .snoop_line(snoop_line)
);

// File: tb/test_vtag_wt_cache.sv
module test_vtag_wt_cache;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0]  cpu_vaddr = '0, cpu_wdata = '0;
   logic [7:0]   cpu_asid = '0;
   logic         cpu_ready;
   logic [31:0]  cpu_rdata;
   logic         mem_req, mem_we;
   logic [31:0]  mem_addr;
   logic [511:0] mem_wdata;
   logic [63:0]  mem_be;
   logic         mem_ack = 1'b0;
   logic [511:0] mem_rdata = '0;
   logic         snoop_valid = 1'b0;
   logic [25:0]  snoop_line = '0;

   int n_cmp = 0, n_bad = 0, fill_cnt = 0;
   bit fill_snoop = 1'b0;
   logic [31:0] last_addr, last_wd;
   logic [63:0] last_be;
   logic [31:0] wmem [logic [31:0]];
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;

   vtag_wt_cache i_vtag_wt_cache (.*);

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] aw;
      aw = {a[31:2], 2'b00};
      if (wmem.exists(aw)) return wmem[aw];
      return {aw[15:0] ^ 16'hBEEF, aw[15:0]};
   endfunction

   task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // memory responder: two wait cycles, then a one-cycle acknowledge
   initial forever begin
      @(negedge clk); #2;
      if (mem_req) begin
         @(negedge clk);
         if (fill_snoop && !mem_we) begin
            snoop_valid = 1'b1;
            snoop_line  = mem_addr[31:6];
         end
         @(negedge clk);
         if (fill_snoop && !mem_we) begin
            snoop_valid = 1'b0;
            fill_snoop  = 1'b0;
         end
         last_addr = mem_addr;
         if (mem_we) begin
            last_be = mem_be;
            for (int w = 0; w < 16; w++)
               if (mem_be[4*w]) begin
                  wmem[mem_addr + 32'(4*w)] = mem_wdata[w*32 +: 32];
                  last_wd = mem_wdata[w*32 +: 32];
               end
         end else begin
            fill_cnt++;
            for (int w = 0; w < 16; w++)
               mem_rdata[w*32 +: 32] = mem_word(mem_addr + 32'(4*w));
         end
         mem_ack = 1'b1;
         @(negedge clk);
         mem_ack = 1'b0;
      end
   end

   // monitor: compares read data as the design produces it
   initial forever begin
      @(negedge clk); #3;
      if (cpu_req && cpu_ready && !cpu_we) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected read completion", 64'(cpu_rdata), 0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(cpu_rdata == e, {t, " read data"}, 64'(cpu_rdata), 64'(e));
         end
      end
   end

   task automatic access(input bit we, input logic [31:0] a, input logic [7:0] asid,
                         input logic [31:0] wd, input bit exp_hit, input string r,
                         input bit snp_same);
      bit first;
      int f0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_vaddr = a; cpu_asid = asid; cpu_wdata = wd;
      if (!we) begin
         exp_q.push_back(mem_word(a));
         tag_q.push_back(r);
      end
      if (snp_same) begin
         snoop_valid = 1'b1;
         snoop_line  = a[31:6];
      end
      f0 = fill_cnt;
      #1;
      first = cpu_ready;
      while (!cpu_ready) begin
         @(negedge clk);
         if (snp_same) snoop_valid = 1'b0;
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0;
      if (snp_same) snoop_valid = 1'b0;
      if (!we) begin
         chk((first && fill_cnt == f0) == exp_hit, {r, " hit/miss"},
             64'(first && fill_cnt == f0), 64'(exp_hit));
         if (!exp_hit)
            chk(last_addr == {a[31:6], 6'b0}, {r, " refill address"},
                64'(last_addr), 64'({a[31:6], 6'b0}));
      end else begin
         chk(!first, {r, " write waits for memory"}, 64'(first), 0);
         chk(last_addr == {a[31:6], 6'b0}, {r, " write address"},
             64'(last_addr), 64'({a[31:6], 6'b0}));
         chk(last_be == (64'hF << (32'(a[5:2]) * 4)), {r, " byte enables"},
             last_be, 64'hF << (32'(a[5:2]) * 4));
         chk(last_wd == wd, {r, " write data"}, 64'(last_wd), 64'(wd));
      end
   endtask

   task automatic snoop(input logic [31:0] a);
      @(negedge clk);
      snoop_valid = 1'b1;
      snoop_line  = a[31:6];
      @(negedge clk);
      snoop_valid = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   localparam logic [31:0] A = 32'h0000_1040;
   localparam logic [31:0] B = 32'h0000_1440;
   localparam logic [31:0] C = 32'h0000_2000;
   localparam logic [31:0] F = 32'h0000_3180;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state: idle ports
      chk(!cpu_ready && !mem_req, "R1 idle after reset", 64'({cpu_ready, mem_req}), 0);
      access(0, A,         8'd1, 0, 0, "R1 first read misses", 0);
      access(0, A + 32'h3C, 8'd1, 0, 1, "R3 other word hits", 0);
      access(0, A + 32'h4,  8'd1, 0, 1, "R3 same line hits", 0);
      access(0, A,         8'd2, 0, 0, "R4 other ASID misses", 0);
      access(0, A,         8'd1, 0, 0, "R4 original ASID replaced", 0);
      access(0, B,         8'd1, 0, 0, "R5 same set other tag misses", 0);
      access(0, A + 32'h8,  8'd1, 0, 0, "R5 evicted line misses", 0);
      access(1, A + 32'h8,  8'd1, 32'hDEAD_0001, 0, "R6 write hit", 0);
      access(0, A + 32'h8,  8'd1, 0, 1, "R7 updated word hits", 0);
      access(1, C + 32'h14, 8'd1, 32'hCAFE_0002, 0, "R8 write miss", 0);
      access(0, C + 32'h14, 8'd1, 0, 0, "R8 no allocation", 0);
      access(0, A,         8'd1, 0, 1, "R9 line resident", 0);
      snoop(A + 32'h20);
      access(0, A,         8'd1, 0, 0, "R9 snooped line misses", 0);
      snoop(A + 32'h400);
      snoop(32'h0000_5000);
      access(0, A + 32'h30, 8'd1, 0, 1, "R12 unrelated snoop keeps line", 0);
      access(0, A,         8'd1, 0, 0, "R10 snoop beats hit", 1);
      access(0, A + 32'hC,  8'd1, 0, 1, "R10 refilled after conflict", 0);
      fill_snoop = 1'b1;
      access(0, F + 32'h10, 8'd3, 0, 0, "R11 read during poisoned fill", 0);
      access(0, F + 32'h10, 8'd3, 0, 0, "R11 poisoned line not kept", 0);
      access(0, F + 32'h10, 8'd3, 0, 1, "R11 clean refill kept", 0);
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all reads completed", 64'(exp_q.size()), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule